// File: doc/BRIEF.md
# Back-Porch Auto Offset Calibrator

This block is a slow digital servo for three video ADC channels. Each channel's converted black level should match a programmed target code. After every clamp interval the block watches a short run of samples from each channel. It reduces them to one average per channel and compares that average with the channel's signed target. It then nudges a 7-bit signed offset control word by one LSB in whichever direction closes the gap. The offset words drive an external analog offset DAC, where one LSB of offset moves the output code by one LSB. That DAC is not part of this block.

Updates can follow every clamp window, or be limited to one per 16, 64 or 128 horizontal syncs. A hold control lets the loop make a single correction and then freeze. With the automatic loop switched off, each offset word simply follows a manual 7-bit value.

Top module: `bp_offset_cal`

## Requirements
- R1: After synchronous reset all three offset words read 0.
- R2: A one-cycle pulse on `clamp_end_i` opens a window of 16 samples, taken on the 16 clock edges that follow the pulse. The window average is the 12-bit sum shifted right by 4, so it is the floor of the mean.
- R3: When an update fires, a channel whose average is below its target steps its offset word by +1, and one whose average is above its target steps by -1. An average equal to the target leaves the word unchanged. The new value appears after the edge that takes the 16th sample.
- R4: In automatic mode every offset word stays within -63..+63 and saturates at those ends.
- R5: Targets are 9-bit two's complement (-256..+255). A channel whose target is 0 is never adjusted.
- R6: In automatic mode an offset word changes only at the end of a window, and by at most one LSB.
- R7: `rate_sel_i` = 0 allows an update at the end of every window. Values 1, 2 and 3 allow one update per 16, 64 or 128 `hsync_i` pulses. After reset the first window may update. A window that ends with no pending line count changes nothing.
- R8: While `hold_i` is high and automatic mode is on, exactly one update is made and then the offsets freeze. The freeze lasts until `hold_i` or `auto_en_i` goes low.
- R9: With `auto_en_i` low, each offset word loads its 7-bit two's complement manual value one clock later. The code -64 is limited to -63. When automatic mode resumes, it starts from that value.
- R10: Each channel's adjustment depends only on its own samples and its own target.
- R11: A `clamp_end_i` pulse that arrives inside a window discards the samples already gathered and restarts the 16-sample window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| clamp_end_i | input | 1 | One-cycle strobe marking the end of the clamp pulse |
| hsync_i | input | 1 | One-cycle strobe per horizontal sync |
| adc_i | input | 24 | Channel samples, channel c at bits [8c+7:8c] |
| target_i | input | 27 | Signed targets, channel c at bits [9c+8:9c] |
| manual_i | input | 21 | Manual offsets, channel c at bits [7c+6:7c] |
| auto_en_i | input | 1 | 1 = automatic servo, 0 = manual offsets |
| hold_i | input | 1 | One-shot calibration then freeze |
| rate_sel_i | input | 2 | Update cadence select |
| offset_o | output | 21 | Signed offset words, channel c at bits [7c+6:7c] |

## Verification
Some properties are checked by assertions on every cycle. These are the offset range limit, the single-LSB step, quiet between window ends, no motion with a zero target, the freeze under hold, the window opening only on a strobe, and the pending-update flag clearing once it is consumed. Other behaviour can only be shown by the bench's scenarios. That covers the direction of each step against the floor-rounded average, the exact sync counts behind each cadence, the restart of a window on a second strobe, the manual load with its -64 limit, and channels moving independently. For these the bench sweeps the targets across the signed range and tracks expected words arithmetically.

// File: rtl/bpoc_pkg.sv
`timescale 1ns/1ps
package bpoc_pkg;

    localparam int SMP_W      = 8;
    localparam int TGT_W      = 9;
    localparam int OFS_W      = 7;
    localparam int WIN_LOG2   = 4;
    localparam int ACC_W      = SMP_W + WIN_LOG2;
    localparam int LINE_CNT_W = 8;

    localparam logic signed [OFS_W-1:0] OFS_POS = {1'b0, {(OFS_W-1){1'b1}}};
    localparam logic signed [OFS_W-1:0] OFS_NEG = {1'b1, {(OFS_W-2){1'b0}}, 1'b1};
    localparam logic        [OFS_W-1:0] OFS_MIN_CODE = {1'b1, {(OFS_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RATE_EVERY = 2'd0,
        RATE_16    = 2'd1,
        RATE_64    = 2'd2,
        RATE_128   = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        DIR_KEEP = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    typedef struct packed {
        logic start;
        logic valid;
        logic last;
    } win_s;

    function automatic logic [LINE_CNT_W-1:0] rate_limit(rate_e r);
        case (r)
            RATE_16:  return LINE_CNT_W'(15);
            RATE_64:  return LINE_CNT_W'(63);
            RATE_128: return LINE_CNT_W'(127);
            default:  return '0;
        endcase
    endfunction

    function automatic dir_e servo_dir(logic [SMP_W-1:0] avg,
                                       logic [TGT_W-1:0] tgt);
        logic signed [TGT_W:0] a;
        logic signed [TGT_W:0] t;
        a = {{(TGT_W+1-SMP_W){1'b0}}, avg};
        t = {tgt[TGT_W-1], tgt};
        if (tgt == '0)
            return DIR_KEEP;
        else if (a < t)
            return DIR_UP;
        else if (a > t)
            return DIR_DOWN;
        else
            return DIR_KEEP;
    endfunction

    function automatic logic signed [OFS_W-1:0] sat_manual(logic [OFS_W-1:0] m);
        if (m == OFS_MIN_CODE)
            return OFS_NEG;
        else
            return m;
    endfunction

endpackage

// File: rtl/bpoc_window.sv
`timescale 1ns/1ps
module bpoc_window
    import bpoc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clamp_end_i,
    output win_s win_o
);

    logic                active_q;
    logic [WIN_LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (clamp_end_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '1)
                active_q <= 1'b0;
        end
    end

    always_comb begin
        win_o.start = clamp_end_i;
        win_o.valid = active_q & ~clamp_end_i;
        win_o.last  = active_q & ~clamp_end_i & (cnt_q == '1);
    end

    AST_WIN_OPENS_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(active_q) |-> $past(clamp_end_i)); // R2

    AST_WIN_CLOSES_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        win_o.last |=> !active_q); // R2

endmodule

// File: rtl/bpoc_rate.sv
`timescale 1ns/1ps
module bpoc_rate
    import bpoc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_i,
    input  logic [1:0] rate_sel_i,
    input  logic       consume_i,
    output logic       due_o
);

    rate_e                 rate;
    logic [LINE_CNT_W-1:0] lim;
    logic [LINE_CNT_W-1:0] cnt_q;
    logic                  pend_q;
    logic                  wrap;

    assign rate = rate_e'(rate_sel_i);
    assign lim  = rate_limit(rate);
    assign wrap = hsync_i && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b1;
        end else begin
            if (hsync_i)
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (consume_i)
                pend_q <= 1'b0;
            if (wrap)
                pend_q <= 1'b1;
        end
    end

    assign due_o = pend_q || (rate == RATE_EVERY);

    AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (consume_i && !hsync_i) |=> !pend_q); // R7

endmodule

// File: rtl/bpoc_chan.sv
`timescale 1ns/1ps
module bpoc_chan
    import bpoc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  win_s                    win_i,
    input  logic                    fire_i,
    input  logic                    auto_en_i,
    input  logic [SMP_W-1:0]        adc_i,
    input  logic [TGT_W-1:0]        tgt_i,
    input  logic [OFS_W-1:0]        manual_i,
    output logic signed [OFS_W-1:0] ofs_o
);

    logic [ACC_W-1:0]        acc_q;
    logic [ACC_W-1:0]        sum;
    logic [SMP_W-1:0]        avg;
    dir_e                    dir;
    logic signed [OFS_W-1:0] ofs_q;

    assign sum = acc_q + {{WIN_LOG2{1'b0}}, adc_i};
    assign avg = sum[ACC_W-1:WIN_LOG2];
    assign dir = servo_dir(avg, tgt_i);

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (win_i.start)
            acc_q <= '0;
        else if (win_i.valid)
            acc_q <= win_i.last ? '0 : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
        end else if (!auto_en_i) begin
            ofs_q <= sat_manual(manual_i);
        end else if (fire_i) begin
            case (dir)
                DIR_UP:   if (ofs_q != OFS_POS) ofs_q <= ofs_q + 1'b1;
                DIR_DOWN: if (ofs_q != OFS_NEG) ofs_q <= ofs_q - 1'b1;
                default:  ;
            endcase
        end
    end

    assign ofs_o = ofs_q;

    AST_OFS_RANGE: assert property (@(posedge clk) disable iff (rst)
        auto_en_i |-> (ofs_o <= OFS_POS) && (ofs_o >= OFS_NEG)); // R4

    AST_ZERO_TARGET_STILL: assert property (@(posedge clk) disable iff (rst)
        (auto_en_i && tgt_i == '0) |=> $stable(ofs_o)); // R5

    AST_QUIET_BETWEEN_WINDOWS: assert property (@(posedge clk) disable iff (rst)
        (auto_en_i && !win_i.last) |=> $stable(ofs_o)); // R6

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        auto_en_i |=> (ofs_o == $past(ofs_o)) ||
                      (ofs_o == OFS_W'($past(ofs_o) + 1'b1)) ||
                      (ofs_o == OFS_W'($past(ofs_o) - 1'b1))); // R6

endmodule

// File: rtl/bp_offset_cal.sv
`timescale 1ns/1ps
module bp_offset_cal
    import bpoc_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clamp_end_i,
    input  logic                 hsync_i,
    input  logic [NCH*SMP_W-1:0] adc_i,
    input  logic [NCH*TGT_W-1:0] target_i,
    input  logic [NCH*OFS_W-1:0] manual_i,
    input  logic                 auto_en_i,
    input  logic                 hold_i,
    input  logic [1:0]           rate_sel_i,
    output logic [NCH*OFS_W-1:0] offset_o
);

    win_s win;
    logic due;
    logic fire;
    logic frozen_q;

    bpoc_window u_window (
        .clk         (clk),
        .rst         (rst),
        .clamp_end_i (clamp_end_i),
        .win_o       (win)
    );

    assign fire = win.last && auto_en_i && due && !frozen_q;

    bpoc_rate u_rate (
        .clk        (clk),
        .rst        (rst),
        .hsync_i    (hsync_i),
        .rate_sel_i (rate_sel_i),
        .consume_i  (fire),
        .due_o      (due)
    );

    always_ff @(posedge clk) begin
        if (rst)
            frozen_q <= 1'b0;
        else if (!hold_i || !auto_en_i)
            frozen_q <= 1'b0;
        else if (fire)
            frozen_q <= 1'b1;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic signed [OFS_W-1:0] ofs;
        bpoc_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .win_i     (win),
            .fire_i    (fire),
            .auto_en_i (auto_en_i),
            .adc_i     (adc_i[c*SMP_W +: SMP_W]),
            .tgt_i     (target_i[c*TGT_W +: TGT_W]),
            .manual_i  (manual_i[c*OFS_W +: OFS_W]),
            .ofs_o     (ofs)
        );
        assign offset_o[c*OFS_W +: OFS_W] = ofs;
    end

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && hold_i && auto_en_i) |=> $stable(offset_o)); // R8

endmodule

// File: tb/bp_offset_cal_tb_top.sv
`timescale 1ns/1ps
module bp_offset_cal_tb_top;

    localparam int NCH = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            clamp_end = 1'b0;
    logic            hsync = 1'b0;
    logic [NCH*8-1:0] adc;
    logic [NCH*9-1:0] target;
    logic [NCH*7-1:0] manual;
    logic            auto_en = 1'b1;
    logic            hold = 1'b0;
    logic [1:0]      rate_sel = 2'd0;
    logic [NCH*7-1:0] offset;

    int smp [NCH];
    int tg  [NCH];
    int mn  [NCH];
    int expv[NCH];
    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            adc[c*8 +: 8]    = smp[c][7:0];
            target[c*9 +: 9] = tg[c][8:0];
            manual[c*7 +: 7] = mn[c][6:0];
        end
    end

    bp_offset_cal #(.NCH(NCH)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .clamp_end_i (clamp_end),
        .hsync_i     (hsync),
        .adc_i       (adc),
        .target_i    (target),
        .manual_i    (manual),
        .auto_en_i   (auto_en),
        .hold_i      (hold),
        .rate_sel_i  (rate_sel),
        .offset_o    (offset)
    );

    function automatic int ofs_of(int c);
        return int'($signed(offset[c*7 +: 7]));
    endfunction

    function automatic int step(int o, int avg, int t);
        if (t == 0) return o;
        if (avg < t && o < 63) return o + 1;
        if (avg > t && o > -63) return o - 1;
        return o;
    endfunction

    task automatic chk(input int act, input int exp, input string rq);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < NCH; c++) expv[c] = 0;
    endtask

    task automatic pulse_hsync(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); hsync = 1'b1;
            @(negedge clk); hsync = 1'b0;
        end
    endtask

    // window of samples base+i (i = 0..15), optional aborted prefix of 255s
    task automatic do_window(input int b0, input int b1, input int b2,
                             input int pre, input bit upd, input string rq);
        int base[NCH];
        int sum [NCH];
        base[0] = b0; base[1] = b1; base[2] = b2;
        for (int c = 0; c < NCH; c++) sum[c] = 0;
        if (pre > 0) begin
            @(negedge clk); clamp_end = 1'b1;
            for (int k = 0; k < pre; k++) begin
                @(negedge clk); clamp_end = 1'b0;
                for (int c = 0; c < NCH; c++) smp[c] = 255;
            end
        end
        @(negedge clk); clamp_end = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); clamp_end = 1'b0;
            if (i == 8)
                for (int c = 0; c < NCH; c++) chk(ofs_of(c), expv[c], "R6 mid-window");
            for (int c = 0; c < NCH; c++) begin
                smp[c] = (base[c] + i) & 255;
                sum[c] += smp[c];
            end
        end
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (upd) expv[c] = step(expv[c], sum[c] / 16, tg[c]);
            chk(ofs_of(c), expv[c], rq);
        end
    endtask

    initial begin
        #600000;
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin smp[c] = 0; tg[c] = 0; mn[c] = 0; end
        do_reset();
        for (int c = 0; c < NCH; c++) chk(ofs_of(c), 0, "R1 reset value");

        // R5: all targets zero, no motion
        do_window(50, 60, 70, 0, 1'b1, "R5 zero target");

        // R3 R10 R5: sweep signed targets, channel 2 kept at zero
        for (int t = -250; t <= 250; t += 25) begin
            if (t == 0) continue;
            tg[0] = t; tg[1] = -t; tg[2] = 0;
            do_window(100, 60, 200, 0, 1'b1, "R3 R10 sweep");
        end

        // R2: floor of mean: base 100 gives avg 107
        tg[0] = 107; tg[1] = 108; tg[2] = 106;
        do_window(100, 100, 100, 0, 1'b1, "R2 R3 equal/floor boundary");

        // R11: restart discards partial window of 255s
        tg[0] = 108; tg[1] = 107; tg[2] = 106;
        do_window(100, 100, 100, 5, 1'b1, "R11 restart");

        // R4: saturation both ways
        tg[0] = 255; tg[1] = 255; tg[2] = 255;
        for (int k = 0; k < 70; k++) do_window(0, 0, 0, 0, 1'b1, "R4 upper saturation");
        for (int c = 0; c < NCH; c++) chk(ofs_of(c), 63, "R4 upper limit");
        tg[0] = -256; tg[1] = -256; tg[2] = -256;
        for (int k = 0; k < 130; k++) do_window(0, 0, 0, 0, 1'b1, "R4 lower saturation");
        for (int c = 0; c < NCH; c++) chk(ofs_of(c), -63, "R4 lower limit");

        // R9: manual mode
        auto_en = 1'b0;
        mn[0] = 64; mn[1] = 63; mn[2] = 5;
        @(negedge clk); @(negedge clk);
        expv[0] = -63; expv[1] = 63; expv[2] = 5;
        for (int c = 0; c < NCH; c++) chk(ofs_of(c), expv[c], "R9 manual load");
        tg[0] = 255; tg[1] = 255; tg[2] = -256;
        do_window(0, 0, 0, 0, 1'b0, "R9 manual ignores window");
        auto_en = 1'b1;
        do_window(0, 0, 0, 0, 1'b1, "R9 auto resumes from manual");

        // R8: hold gives one update then freezes
        tg[0] = 255; tg[1] = -256; tg[2] = 255;
        hold = 1'b1;
        do_window(0, 0, 0, 0, 1'b1, "R8 hold first update");
        do_window(0, 0, 0, 0, 1'b0, "R8 frozen");
        do_window(0, 0, 0, 0, 1'b0, "R8 still frozen");
        hold = 1'b0;
        do_window(0, 0, 0, 0, 1'b1, "R8 released");

        // R7: line-count cadence
        rate_sel = 2'd2;
        do_reset();
        tg[0] = 255; tg[1] = -256; tg[2] = 0;
        do_window(0, 0, 0, 0, 1'b1, "R7 first window after reset");
        do_window(0, 0, 0, 0, 1'b0, "R7 no pending count");
        pulse_hsync(63);
        do_window(0, 0, 0, 0, 1'b0, "R7 63 syncs not enough");
        pulse_hsync(1);
        do_window(0, 0, 0, 0, 1'b1, "R7 64th sync allows update");
        do_window(0, 0, 0, 0, 1'b0, "R7 consumed");
        rate_sel = 2'd1;
        pulse_hsync(15);
        do_window(0, 0, 0, 0, 1'b0, "R7 15 syncs not enough");
        pulse_hsync(1);
        do_window(0, 0, 0, 0, 1'b1, "R7 16th sync allows update");
        rate_sel = 2'd3;
        pulse_hsync(127);
        do_window(0, 0, 0, 0, 1'b0, "R7 127 syncs not enough");
        pulse_hsync(1);
        do_window(0, 0, 0, 0, 1'b1, "R7 128th sync allows update");
        rate_sel = 2'd0;
        do_window(0, 0, 0, 0, 1'b1, "R7 every window");
        do_window(0, 0, 0, 0, 1'b1, "R7 every window again");

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule